// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block hands the processor's primary bus to an external master through a request/acknowledge handshake. The master pulls an asynchronous active-low request pin. The block synchronizes the pin and qualifies it over a minimum number of cycles. It waits until any bus cycle already in progress has finished. It then raises the acknowledge and turns off the drivers for strobe, read/write, address and data. When the request goes away, the drivers come back and the acknowledge drops.

The core keeps running while the bus is held. Only an access to the primary bus can stall it. One write issued during hold is taken into a single-entry posted buffer without stalling the core. A second write, or any read, stalls until the bus is returned. When hold ends, the buffered write goes onto the bus before any new core access. A control input can override the handshake: while it is set, an active hold ends on the next clock and every later request is refused.

Top module: `hold_arbiter`

## Requirements
- R1: With the bus idle, `hold_ack` rises exactly SYNC_STAGES+MIN_HOLD_CYC clock edges after the first edge that sees `hold_n` low. A low pulse covering fewer than MIN_HOLD_CYC edges never produces `hold_ack`.
- R2: `hold_ack` never rises while `bus_strobe` is high. A request that arrives during a bus cycle is granted on the edge after the first idle cycle, or after the latency of R1 if that is later.
- R3: While `hold_ack` is 1, `strb_oe`, `rw_oe`, `addr_oe` and `data_oe` are all 0. While `hold_ack` is 0, `strb_oe`, `rw_oe` and `addr_oe` are 1.
- R4: `hold_ack` falls SYNC_STAGES+1 edges after the first edge that sees `hold_n` high.
- R5: While `nohold` is 1, `hold_ack` is 0 from the next edge on, whatever the state of `hold_n`. Core accesses then proceed without stalling.
- R6: `core_stall` is 0 when `core_req` is 0. An access requested with the bus idle and no hold pending is accepted without a stall. While held with the buffer empty, a write (`core_we`=1) is accepted without a stall.
- R7: While held with a write already buffered, any further access (write or read) has `core_stall`=1, and `bus_strobe` stays 0.
- R8: After hold ends, the first bus cycle carries the buffered write's address and data. A stalled core access follows it afterwards.
- R9: A bus cycle holds `bus_strobe` high for exactly BUS_CYC cycles. `bus_rd`=0 and `data_oe`=1 for a write; `bus_rd`=1 and `data_oe`=0 for a read.
- R10: Reset deasserts `hold_ack`, enables the strobe, read/write and address drivers, and discards a buffered write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_n | input | 1 | Asynchronous active-low hold request from the external master |
| nohold | input | 1 | Hold override: ends any hold and refuses new ones |
| core_req | input | 1 | Core requests a primary-bus access |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | AW | Access address |
| core_wdata | input | DW | Write data |
| core_stall | output | 1 | Access not accepted this cycle; core must wait |
| hold_ack | output | 1 | Hold acknowledge, active high |
| bus_strobe | output | 1 | Bus cycle strobe, active high |
| bus_rd | output | 1 | 1 = read or idle, 0 = write |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| strb_oe | output | 1 | Strobe driver enable |
| rw_oe | output | 1 | Read/write driver enable |
| addr_oe | output | 1 | Address driver enable |
| data_oe | output | 1 | Data driver enable |

## Verification
The bench builds the block with 8-bit address and data and BUS_CYC=5. SYNC_STAGES and MIN_HOLD_CYC keep their default of 2. With these values the bench can sweep request pulse widths from 1 to 5 cycles, which brings both the rejected short pulse and the exact grant and release latencies within reach. The five-cycle bus cycle lets the bench place the request on every cycle offset of a strobe, so it sees the grant held back by a cycle in progress and also the grant limited only by synchronizer latency.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

    typedef enum logic {
        HS_OWNED   = 1'b0,
        HS_GRANTED = 1'b1
    } hold_state_e;

    typedef enum logic {
        SQ_IDLE   = 1'b0,
        SQ_STROBE = 1'b1
    } seq_phase_e;

    // width able to hold values 0..n
    function automatic int unsigned cnt_width(input int unsigned n);
        return $clog2(n + 1) + 1;
    endfunction

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_n_async,
    output logic req_o
);
    logic [SYNC_STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[SYNC_STAGES-2:0], ~hold_n_async};
    end

    assign req_o = chain_q[SYNC_STAGES-1];

    initial begin
        assert (SYNC_STAGES >= 2) else $error("synchronizer needs at least two stages");
    end
endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl
    import hold_arb_pkg::*;
#(
    parameter int MIN_HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic nohold_i,
    input  logic busy_i,
    input  logic pend_i,
    output logic want_o,
    output logic holda_o
);
    localparam int QW = cnt_width(MIN_HOLD_CYC);
    localparam logic [QW-1:0] QUAL_DONE = QW'(MIN_HOLD_CYC - 1);

    logic [QW-1:0] qual_q;
    hold_state_e   state_q;
    logic          qualified;

    // count consecutive synchronized request cycles, saturating
    always_ff @(posedge clk) begin
        if (rst)                    qual_q <= '0;
        else if (!req_i)            qual_q <= '0;
        else if (qual_q != QUAL_DONE) qual_q <= qual_q + 1'b1;
    end

    assign qualified = req_i && (qual_q == QUAL_DONE);
    assign want_o    = qualified && !nohold_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_OWNED;
        end else begin
            unique case (state_q)
                HS_OWNED:
                    if (want_o && !busy_i && !pend_i) state_q <= HS_GRANTED;
                HS_GRANTED:
                    if (!req_i || nohold_i) state_q <= HS_OWNED;
                default: state_q <= HS_OWNED;
            endcase
        end
    end

    assign holda_o = (state_q == HS_GRANTED);

    assert_grant_after_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(holda_o) |-> !$past(busy_i));

    assert_override_drops_R5: assert property (@(posedge clk) disable iff (rst)
        nohold_i |=> !holda_o);

    assert_release_on_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (holda_o && !req_i) |=> !holda_o);

    generate
        if (MIN_HOLD_CYC >= 2) begin : g_qual_chk
            assert_grant_qualified_R1: assert property (@(posedge clk) disable iff (rst)
                $rose(holda_o) |-> ($past(req_i) && $past(req_i, 2)));
        end else begin : g_qual_chk1
            assert_grant_qualified_R1: assert property (@(posedge clk) disable iff (rst)
                $rose(holda_o) |-> $past(req_i));
        end
    endgenerate
endmodule

// File: rtl/bus_seq.sv
module bus_seq
    import hold_arb_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int BUS_CYC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          core_req,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    input  logic          holda_i,
    input  logic          want_i,
    output logic          core_stall,
    output logic          busy_o,
    output logic          pend_o,
    output logic          bus_strobe,
    output logic          bus_rd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          data_oe
);
    localparam int CW = cnt_width(BUS_CYC);

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } access_t;

    access_t    op_q, pend_q, core_acc;
    logic       pend_v;
    seq_phase_e phase_q;
    logic [CW-1:0] left_q;
    logic       busy, start_pend, start_core, post;

    always_comb begin
        core_acc.we   = core_we;
        core_acc.addr = core_addr;
        core_acc.data = core_wdata;
    end

    assign busy       = (phase_q == SQ_STROBE);
    // buffered write drains first once the bus is back
    assign start_pend = pend_v && !busy && !holda_i;
    assign start_core = core_req && !busy && !pend_v && !holda_i && !want_i;
    assign post       = core_req && core_we && holda_i && !pend_v;
    assign core_stall = core_req && !start_core && !post;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= SQ_IDLE;
            left_q  <= '0;
            op_q    <= '0;
        end else if (start_pend) begin
            phase_q <= SQ_STROBE;
            left_q  <= CW'(BUS_CYC - 1);
            op_q    <= pend_q;
        end else if (start_core) begin
            phase_q <= SQ_STROBE;
            left_q  <= CW'(BUS_CYC - 1);
            op_q    <= core_acc;
        end else if (busy) begin
            if (left_q == '0) phase_q <= SQ_IDLE;
            else              left_q  <= left_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend_q <= '0;
        end else if (post) begin
            pend_v <= 1'b1;
            pend_q <= core_acc;
        end else if (start_pend) begin
            pend_v <= 1'b0;
        end
    end

    assign busy_o     = busy;
    assign pend_o     = pend_v;
    assign bus_strobe = busy;
    assign bus_rd     = busy ? !op_q.we : 1'b1;
    assign bus_addr   = op_q.addr;
    assign bus_wdata  = op_q.data;
    assign data_oe    = busy && op_q.we;

    assert_post_accepted_R6: assert property (@(posedge clk) disable iff (rst)
        (core_req && core_we && holda_i && !pend_v) |=> pend_v);

    assert_second_stalls_R7: assert property (@(posedge clk) disable iff (rst)
        (holda_i && pend_v && core_req) |-> core_stall);

    assert_pending_first_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(holda_i) && pend_v) |=> (busy && op_q.we));

    assert_no_strobe_in_hold_R2: assert property (@(posedge clk) disable iff (rst)
        holda_i |-> !busy);
endmodule

// File: rtl/hold_arbiter.sv
module hold_arbiter #(
    parameter int AW           = 16,
    parameter int DW           = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int MIN_HOLD_CYC = 2,
    parameter int BUS_CYC      = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold_n,
    input  logic          nohold,
    input  logic          core_req,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic          core_stall,
    output logic          hold_ack,
    output logic          bus_strobe,
    output logic          bus_rd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          strb_oe,
    output logic          rw_oe,
    output logic          addr_oe,
    output logic          data_oe
);
    logic req_s, want, busy, pend, holda;

    hold_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .hold_n_async(hold_n), .req_o(req_s)
    );

    hold_ctrl #(.MIN_HOLD_CYC(MIN_HOLD_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .req_i(req_s), .nohold_i(nohold),
        .busy_i(busy), .pend_i(pend), .want_o(want), .holda_o(holda)
    );

    bus_seq #(.AW(AW), .DW(DW), .BUS_CYC(BUS_CYC)) u_seq (
        .clk(clk), .rst(rst), .core_req(core_req), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .holda_i(holda), .want_i(want), .core_stall(core_stall),
        .busy_o(busy), .pend_o(pend), .bus_strobe(bus_strobe),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .data_oe(data_oe)
    );

    assign hold_ack = holda;
    assign strb_oe  = !holda;
    assign rw_oe    = !holda;
    assign addr_oe  = !holda;

    assert_data_off_in_hold_R3: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> !hold_ack);

    assert_reset_clears_R10: assert property (@(posedge clk)
        $past(rst) |-> (!hold_ack && strb_oe && addr_oe));
endmodule

// File: tb/hold_arbiter_test.sv
`timescale 1ns/1ps
module hold_arbiter_test;
    localparam int AW = 8, DW = 8, SYNC = 2, MINH = 2, BUS = 5;

    logic clk = 1'b0, rst = 1'b1, hold_n = 1'b1, nohold = 1'b0;
    logic core_req = 1'b0, core_we = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0;
    logic core_stall, hold_ack, bus_strobe, bus_rd, strb_oe, rw_oe, addr_oe, data_oe;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    hold_arbiter #(.AW(AW), .DW(DW), .SYNC_STAGES(SYNC), .MIN_HOLD_CYC(MINH), .BUS_CYC(BUS)) uut (
        .clk(clk), .rst(rst), .hold_n(hold_n), .nohold(nohold),
        .core_req(core_req), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_stall(core_stall), .hold_ack(hold_ack), .bus_strobe(bus_strobe), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .strb_oe(strb_oe), .rw_oe(rw_oe),
        .addr_oe(addr_oe), .data_oe(data_oe)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic check_oe(input string tag);
        int got, exp;
        got = {strb_oe, rw_oe, addr_oe, data_oe};
        if (hold_ack) exp = 0;
        else exp = {3'b111, data_oe};
        check(got == exp, tag, got, exp);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int t0, first, drop, e0, len, exp;
        int n_st;
        int st_addr[2];
        int st_data[2];
        int st_we[2];
        logic prev_st;

        // R10: reset state
        @(negedge clk);
        step(); step(); step();
        check(hold_ack == 1'b0, "R10 holda in reset", hold_ack, 0);
        check({strb_oe, rw_oe, addr_oe} == 3'b111, "R10 drivers on", {strb_oe, rw_oe, addr_oe}, 7);
        check(core_stall == 1'b0, "R6 no stall without req", core_stall, 0);
        check(bus_strobe == 1'b0, "R10 no strobe", bus_strobe, 0);
        rst = 1'b0;
        step();

        // R1/R4/R3: pulse width sweep
        for (int w = 1; w <= 5; w++) begin
            t0 = cyc; first = -1; drop = -1;
            hold_n = 1'b0;
            for (int i = 0; i < 15; i++) begin
                if (i == w) hold_n = 1'b1;
                step();
                if (hold_ack && first < 0) first = cyc - t0;
                if (!hold_ack && first >= 0 && drop < 0) drop = cyc - t0;
                check_oe("R3 enables vs hold_ack");
            end
            if (w >= MINH) begin
                check(first == SYNC + MINH, "R1 grant latency", first, SYNC + MINH);
                check(drop == w + SYNC + 1, "R4 release latency", drop, w + SYNC + 1);
            end else begin
                check(first == -1, "R1 short pulse ignored", first, -1);
            end
        end

        // R2/R9: request at each offset inside a write cycle
        for (int o = 0; o < BUS; o++) begin
            core_req = 1'b1; core_we = 1'b1;
            core_addr = AW'(8'h10 + o); core_wdata = DW'(8'hA0 + o);
            #1;
            check(core_stall == 1'b0, "R6 idle access no stall", core_stall, 0);
            step();
            core_req = 1'b0;
            e0 = cyc; first = -1; len = 0;
            for (int i = 0; i < 20; i++) begin
                if (bus_strobe) begin
                    len++;
                    check(data_oe && !bus_rd && bus_addr == AW'(8'h10 + o) && bus_wdata == DW'(8'hA0 + o),
                          "R9 write cycle fields", {data_oe, bus_rd}, 2);
                    check(!hold_ack, "R2 no hold during strobe", hold_ack, 0);
                end
                if (hold_ack && first < 0) first = cyc - e0;
                if (i == o) hold_n = 1'b0;
                step();
            end
            exp = (o + SYNC + MINH > BUS + 1) ? o + SYNC + MINH : BUS + 1;
            check(len == BUS, "R9 strobe length", len, BUS);
            check(first == exp, "R2 grant waits for cycle end", first, exp);
            hold_n = 1'b1;
            for (int i = 0; i < 6; i++) step();
            check(hold_ack == 1'b0, "R4 released", hold_ack, 0);
        end

        // R9: read cycle
        core_req = 1'b1; core_we = 1'b0; core_addr = 8'h33;
        step();
        core_req = 1'b0;
        check(bus_strobe && bus_rd && !data_oe && bus_addr == 8'h33, "R9 read cycle",
              {bus_strobe, bus_rd, data_oe}, 6);
        for (int i = 0; i < 6; i++) step();

        // R6/R7/R8: posted write during hold
        hold_n = 1'b0;
        for (int i = 0; i < 5; i++) step();
        check(hold_ack == 1'b1, "R1 hold granted", hold_ack, 1);
        check_oe("R3 drivers off in hold");
        core_req = 1'b1; core_we = 1'b1; core_addr = 8'hAA; core_wdata = 8'h55;
        #1;
        check(core_stall == 1'b0, "R6 first write posted", core_stall, 0);
        step();
        core_addr = 8'hBB; core_wdata = 8'h66; core_we = 1'b0;
        #1;
        check(core_stall == 1'b1, "R7 read stalls", core_stall, 1);
        core_we = 1'b1;
        #1;
        check(core_stall == 1'b1, "R7 second write stalls", core_stall, 1);
        for (int i = 0; i < 3; i++) begin
            step();
            check(core_stall && !bus_strobe, "R7 stall held, bus quiet", {core_stall, bus_strobe}, 2);
        end
        hold_n = 1'b1;
        n_st = 0; prev_st = 1'b0;
        for (int i = 0; i < 30; i++) begin
            bit accept;
            accept = core_req && !core_stall;
            if (bus_strobe && !prev_st && n_st < 2) begin
                st_addr[n_st] = bus_addr; st_data[n_st] = bus_wdata; st_we[n_st] = !bus_rd;
                n_st++;
            end
            prev_st = bus_strobe;
            step();
            if (accept) core_req = 1'b0;
        end
        check(n_st == 2, "R8 two cycles after release", n_st, 2);
        check(st_addr[0] == 8'hAA && st_data[0] == 8'h55 && st_we[0] == 1, "R8 buffered write first",
              st_addr[0], 8'hAA);
        check(st_addr[1] == 8'hBB && st_data[1] == 8'h66 && st_we[1] == 1, "R8 stalled write second",
              st_addr[1], 8'hBB);

        // R5: override
        hold_n = 1'b0;
        for (int i = 0; i < 5; i++) step();
        check(hold_ack == 1'b1, "R5 hold before override", hold_ack, 1);
        nohold = 1'b1;
        step();
        check(hold_ack == 1'b0, "R5 override exits hold", hold_ack, 0);
        check_oe("R3 drivers back on");
        for (int i = 0; i < 4; i++) begin
            step();
            check(hold_ack == 1'b0, "R5 later hold refused", hold_ack, 0);
        end
        core_req = 1'b1; core_we = 1'b1; core_addr = 8'h44; core_wdata = 8'h11;
        #1;
        check(core_stall == 1'b0, "R5 core runs under override", core_stall, 0);
        step();
        core_req = 1'b0;
        check(bus_strobe == 1'b1, "R5 access on bus", bus_strobe, 1);
        for (int i = 0; i < BUS + 1; i++) step();
        nohold = 1'b0;
        step();
        check(hold_ack == 1'b1, "R5 hold resumes when cleared", hold_ack, 1);
        hold_n = 1'b1;
        for (int i = 0; i < 5; i++) step();

        // R10: reset discards buffered write
        hold_n = 1'b0;
        for (int i = 0; i < 5; i++) step();
        core_req = 1'b1; core_we = 1'b1; core_addr = 8'h77; core_wdata = 8'h88;
        step();
        core_req = 1'b0;
        rst = 1'b1;
        step();
        check(hold_ack == 1'b0 && strb_oe && addr_oe, "R10 reset mid hold", hold_ack, 0);
        rst = 1'b0; hold_n = 1'b1;
        len = 0;
        for (int i = 0; i < 10; i++) begin
            step();
            if (bus_strobe) len++;
        end
        check(len == 0, "R10 buffer discarded", len, 0);

        finish_run();
    end
endmodule